// File: doc/BRIEF.md
# Parallel Multi-Output Galois LFSR

This block produces several consecutive states of an internal-XOR (Galois) linear feedback shift register in one step. A base register holds the starting state of a batch. A chain of state registers is loaded from it. The first chain register takes the base unchanged. Each later chain register takes the base advanced by a fixed number of Galois steps, computed by its own combinational jump-ahead network. All lanes except the last are driven out to separate consumers as consecutive pseudo-random states. The last chain register is written back into the base so that the next batch carries on from where the previous batch ended.

The feedback polynomial is held in a configuration register that can be rewritten at run time, so any polynomial of degree `WIDTH` can be used. A synchronous load puts a seed into the base and marks the outputs invalid. While the enable is held, the block alternates between a spread cycle, which fills the chain from the base, and a recycle cycle, which moves the last chain stage into the base. This yields `STAGES-1` new states every two enabled cycles.

Top module: `plfsr_galois`

## Requirements
- R1: After reset, `valid_o` and `fresh_o` are 0 and every lane of `lanes_o` is 0.
- R2: With state bits s[0]..s[W-1] and tap bit `poly_i[b-1]` as the coefficient of x^b (b = 1..W-1), one Galois step gives s'[0] = s[W-1] and s'[b] = s[b-1] xor (tap_b and s[W-1]). Lane j, at bits [j*W +: W] of `lanes_o`, holds the batch base advanced j steps, so lane 0 is the base unchanged.
- R3: When `load_i` is high at a clock edge, `seed_i` becomes the base and `valid_o` and `fresh_o` are 0 after that edge, even if `en_i` is high at the same edge.
- R4: The first enabled edge after a load fills the lanes from the seed, and `valid_o` and `fresh_o` are 1 after that edge.
- R5: With `en_i` held high, `fresh_o` pulses for one cycle every second cycle, and a new batch appears only in a cycle where `fresh_o` is 1.
- R6: Lane 0 of each new batch equals the previous batch base advanced STAGES-1 steps, so the lanes of successive batches form one unbroken serial sequence with no gaps or repeats.
- R7: While `en_i` and `load_i` are low, the lanes and the base do not change and `fresh_o` is 0. Enabling again resumes the sequence where it stopped.
- R8: `poly_wr_i` stores `poly_i` at the clock edge. The stored taps do not alter lanes already present, and they govern the next spread cycle.
- R9: With WIDTH=5, STAGES=3, taps for 1 + x^3 + x^5 (`poly_i` = 4'b0100) and seed 5'b10000, the first batch is (10000, 01001) and the second is (10010, 01101).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| poly_wr_i | input | 1 | Write strobe for the tap configuration register |
| poly_i | input | WIDTH-1 | Tap coefficients; bit b-1 is the coefficient of x^b |
| load_i | input | 1 | Synchronous seed load; has priority over `en_i` |
| seed_i | input | WIDTH | Seed state for the base register |
| en_i | input | 1 | Advance enable |
| lanes_o | output | (STAGES-1)*WIDTH | Consecutive states, lane j at bits [j*WIDTH +: WIDTH] |
| valid_o | output | 1 | Lanes hold a batch computed since the last load |
| fresh_o | output | 1 | One-cycle pulse when a new batch has been registered |

## Verification
The main function is run against a serial Galois model with zero taps, which makes the register a pure rotation and exposes any lane misplacement or wrong shift direction. It is also run with all taps set, which makes every bit depend on the feedback, and with two primitive polynomials whose taps sit at different positions, from single-bit, sparse and dense seeds. Continuity across many batches separates a correct feedback of the last stage from an off-by-one advance. The hand-worked five-bit case fixes which end of the register feeds back and where the coefficient bits apply.

// File: rtl/plfsr_pkg.sv
package plfsr_pkg;

    // Two-cycle cadence of the chain: fill the lanes, then recycle the last stage.
    typedef enum logic {
        PH_SPREAD  = 1'b0,
        PH_RECYCLE = 1'b1
    } phase_e;

    localparam int unsigned MAX_WIDTH  = 16;
    localparam int unsigned MAX_STAGES = 4;

endpackage

// File: rtl/plfsr_jump.sv
// Combinational jump-ahead: applies the Galois step POWER times.
module plfsr_jump #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned POWER = 1
) (
    input  logic [WIDTH-1:0] state_i,
    input  logic [WIDTH-2:0] taps_i,
    output logic [WIDTH-1:0] state_o
);

    function automatic logic [WIDTH-1:0] galois_step(
        input logic [WIDTH-1:0] s,
        input logic [WIDTH-2:0] t
    );
        logic [WIDTH-1:0] n;
        n[0] = s[WIDTH-1];
        for (int b = 1; b < WIDTH; b++) begin
            n[b] = s[b-1] ^ (t[b-1] & s[WIDTH-1]);
        end
        return n;
    endfunction

    logic [WIDTH-1:0] acc;

    always_comb begin
        acc = state_i;
        for (int p = 0; p < POWER; p++) begin
            acc = galois_step(acc, taps_i);
        end
    end

    assign state_o = acc;

endmodule

// File: rtl/plfsr_ctrl.sv
// Cadence control: spread / recycle alternation and batch flags.
module plfsr_ctrl (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic load_i,
    input  logic en_i,
    output logic spread_o,
    output logic recycle_o,
    output logic valid_o,
    output logic fresh_o
);
    import plfsr_pkg::*;

    typedef struct packed {
        phase_e phase;
        logic   valid;
        logic   fresh;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    assign spread_o  = en_i && !load_i && (ctrl_q.phase == PH_SPREAD);
    assign recycle_o = en_i && !load_i && (ctrl_q.phase == PH_RECYCLE);

    always_comb begin
        ctrl_d       = ctrl_q;
        ctrl_d.fresh = 1'b0;
        if (load_i) begin
            ctrl_d.phase = PH_SPREAD;
            ctrl_d.valid = 1'b0;
        end else if (spread_o) begin
            ctrl_d.phase = PH_RECYCLE;
            ctrl_d.valid = 1'b1;
            ctrl_d.fresh = 1'b1;
        end else if (recycle_o) begin
            ctrl_d.phase = PH_SPREAD;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctrl_q <= '{phase: PH_SPREAD, valid: 1'b0, fresh: 1'b0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign valid_o = ctrl_q.valid;
    assign fresh_o = ctrl_q.fresh;

    // R3: a load leaves the outputs marked invalid
    a_r3_load_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (!valid_o && !fresh_o));

    // R4: a fresh batch is always a valid one
    a_r4_fresh_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fresh_o |-> valid_o);

    // R5: a fresh pulse lasts one cycle
    a_r5_fresh_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fresh_o |=> !fresh_o);

    // R7: no new batch without the enable
    a_r7_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> !fresh_o);

endmodule

// File: rtl/plfsr_galois.sv
// Parallel multi-output Galois LFSR: base register, chain of jump-ahead stages.
module plfsr_galois #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 4
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          poly_wr_i,
    input  logic [WIDTH-2:0]              poly_i,
    input  logic                          load_i,
    input  logic [WIDTH-1:0]              seed_i,
    input  logic                          en_i,
    output logic [(STAGES-1)*WIDTH-1:0]   lanes_o,
    output logic                          valid_o,
    output logic                          fresh_o
);
    import plfsr_pkg::*;

    localparam int unsigned CHAIN_W = STAGES * WIDTH;
    localparam int unsigned LANES_W = (STAGES - 1) * WIDTH;
    localparam int unsigned LAST_LO = (STAGES - 1) * WIDTH;

    initial begin
        if (STAGES < 2 || STAGES > MAX_STAGES || WIDTH < 3 || WIDTH > MAX_WIDTH)
            $error("plfsr_galois: parameters out of range");
    end

    typedef struct packed {
        logic [WIDTH-2:0]   taps;
        logic [WIDTH-1:0]   base;
        logic [CHAIN_W-1:0] chain;
    } dp_t;

    dp_t dp_d, dp_q;

    logic               spread_w;
    logic               recycle_w;
    logic [CHAIN_W-1:0] jump_w;
    logic [WIDTH-1:0]   last_w;

    plfsr_ctrl u_ctrl (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .load_i    (load_i),
        .en_i      (en_i),
        .spread_o  (spread_w),
        .recycle_o (recycle_w),
        .valid_o   (valid_o),
        .fresh_o   (fresh_o)
    );

    // Stage i holds the base advanced i-1 steps; stage 1 is a plain copy.
    for (genvar i = 1; i <= STAGES; i++) begin : g_stage
        if (i == 1) begin : g_copy
            assign jump_w[0 +: WIDTH] = dp_q.base;
        end else begin : g_jump
            plfsr_jump #(
                .WIDTH (WIDTH),
                .POWER (i - 1)
            ) u_jump (
                .state_i (dp_q.base),
                .taps_i  (dp_q.taps),
                .state_o (jump_w[(i-1)*WIDTH +: WIDTH])
            );
        end
    end

    assign last_w = dp_q.chain[LAST_LO +: WIDTH];

    always_comb begin
        dp_d = dp_q;
        if (poly_wr_i) begin
            dp_d.taps = poly_i;
        end
        if (load_i) begin
            dp_d.base = seed_i;
        end else if (recycle_w) begin
            dp_d.base = last_w;
        end
        if (spread_w) begin
            dp_d.chain = jump_w;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign lanes_o = dp_q.chain[LANES_W-1:0];

    // R2: right after a spread the first lane equals the unchanged base
    a_r2_lane0_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fresh_o |-> (lanes_o[0 +: WIDTH] == dp_q.base));

    // R6: a recycle cycle hands the last stage to the base
    a_r6_recycle_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
        recycle_w |=> (dp_q.base == $past(last_w)));

    // R7: idle cycles leave lanes and base untouched
    a_r7_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en_i && !load_i) |=> ($stable(dp_q.chain) && $stable(dp_q.base)));

    // R8: taps change only on a write strobe
    a_r8_taps_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !poly_wr_i |=> $stable(dp_q.taps));

endmodule

// File: tb/plfsr_galois_bench.sv
`timescale 1ns/1ps
module plfsr_galois_bench;

    localparam int unsigned W  = 8;
    localparam int unsigned K  = 4;
    localparam int unsigned NL = K - 1;

    typedef struct packed {
        logic [W-2:0] taps;
        logic [W-1:0] seed;
        logic [7:0]   batches;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{taps: 7'b0000000, seed: 8'h01, batches: 8'd4},
        '{taps: 7'b0111000, seed: 8'h01, batches: 8'd8},
        '{taps: 7'b0001110, seed: 8'hA5, batches: 8'd6},
        '{taps: 7'b1111111, seed: 8'hFF, batches: 8'd5},
        '{taps: 7'b0111000, seed: 8'h80, batches: 8'd90}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic               poly_wr = 1'b0;
    logic [W-2:0]       poly = '0;
    logic               load = 1'b0;
    logic [W-1:0]       seed = '0;
    logic               en = 1'b0;
    logic [NL*W-1:0]    lanes;
    logic               valid;
    logic               fresh;

    plfsr_galois #(.WIDTH(W), .STAGES(K)) u_plfsr_galois (
        .clk_i (clk), .rst_ni (rst_n), .poly_wr_i (poly_wr), .poly_i (poly),
        .load_i (load), .seed_i (seed), .en_i (en),
        .lanes_o (lanes), .valid_o (valid), .fresh_o (fresh)
    );

    logic       s_poly_wr = 1'b0;
    logic [3:0] s_poly = '0;
    logic       s_load = 1'b0;
    logic [4:0] s_seed = '0;
    logic       s_en = 1'b0;
    logic [9:0] s_lanes;
    logic       s_valid;
    logic       s_fresh;

    plfsr_galois #(.WIDTH(5), .STAGES(3)) u_plfsr_galois_w5 (
        .clk_i (clk), .rst_ni (rst_n), .poly_wr_i (s_poly_wr), .poly_i (s_poly),
        .load_i (s_load), .seed_i (s_seed), .en_i (s_en),
        .lanes_o (s_lanes), .valid_o (s_valid), .fresh_o (s_fresh)
    );

    int n_checks = 0;
    int n_fail   = 0;

    function automatic logic [W-1:0] ref_step(input logic [W-1:0] s, input logic [W-2:0] t);
        logic [W-1:0] n;
        n[0] = s[W-1];
        for (int b = 1; b < W; b++) n[b] = s[b-1] ^ (t[b-1] & s[W-1]);
        return n;
    endfunction

    function automatic logic [W-1:0] ref_adv(input logic [W-1:0] s, input logic [W-2:0] t, input int n);
        logic [W-1:0] r = s;
        for (int i = 0; i < n; i++) r = ref_step(r, t);
        return r;
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_lanes(input string req, input logic [W-1:0] base, input logic [W-2:0] t);
        for (int j = 0; j < NL; j++)
            chk(req, 16'(lanes[j*W +: W]), 16'(ref_adv(base, t, j)));
    endtask

    task automatic write_load(input logic [W-2:0] t, input logic [W-1:0] s);
        poly_wr = 1'b1; poly = t;
        @(negedge clk);
        poly_wr = 1'b0; load = 1'b1; seed = s;
        @(negedge clk);
        load = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        logic [W-1:0] r;
        logic [W-2:0] t;
        logic [NL*W-1:0] held;

        // R1: reset state
        @(negedge clk);
        chk("R1 lanes", 16'(lanes), 16'h0);
        chk("R1 valid", 16'(valid), 16'h0);
        chk("R1 fresh", 16'(fresh), 16'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: serial model comparison across batches
        foreach (VECS[v]) begin
            write_load(VECS[v].taps, VECS[v].seed);
            chk("R3 valid after load", 16'(valid), 16'h0);
            en = 1'b1;
            r = VECS[v].seed;
            for (int b = 0; b < int'(VECS[v].batches); b++) begin
                @(negedge clk);
                chk("R4 fresh", 16'(fresh), 16'h1);
                chk("R4 valid", 16'(valid), 16'h1);
                chk_lanes("R2/R6 lanes", r, VECS[v].taps);
                r = ref_adv(r, VECS[v].taps, NL);
                @(negedge clk);
                chk("R5 no fresh in recycle", 16'(fresh), 16'h0);
            end
            en = 1'b0;
            @(negedge clk);
        end

        // R7: pause and resume
        t = 7'b0111000;
        write_load(t, 8'h5A);
        en = 1'b1;
        r = 8'h5A;
        @(negedge clk);
        chk_lanes("R7 before pause", r, t);
        held = lanes;
        en = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 lanes held", 16'(lanes), 16'(held));
        chk("R7 fresh low", 16'(fresh), 16'h0);
        chk("R7 valid kept", 16'(valid), 16'h1);

        // R8: new taps leave present lanes alone, then govern next spread
        poly_wr = 1'b1; poly = 7'b0001110;
        @(negedge clk);
        poly_wr = 1'b0;
        chk("R8 lanes unchanged", 16'(lanes), 16'(held));
        en = 1'b1;
        @(negedge clk);
        chk("R7 recycle after resume", 16'(fresh), 16'h0);
        @(negedge clk);
        r = ref_adv(r, t, NL);
        chk("R8 fresh", 16'(fresh), 16'h1);
        chk_lanes("R8 lanes new taps", r, 7'b0001110);
        t = 7'b0001110;

        // R3: load wins over enable mid-run
        load = 1'b1; seed = 8'hC3;
        @(negedge clk);
        load = 1'b0;
        chk("R3 valid cleared", 16'(valid), 16'h0);
        chk("R3 fresh cleared", 16'(fresh), 16'h0);
        @(negedge clk);
        chk("R4 fresh after reload", 16'(fresh), 16'h1);
        chk_lanes("R3 lanes from new seed", 8'hC3, t);
        en = 1'b0;

        // R9: five-bit worked example
        s_poly_wr = 1'b1; s_poly = 4'b0100;
        @(negedge clk);
        s_poly_wr = 1'b0; s_load = 1'b1; s_seed = 5'b10000;
        @(negedge clk);
        s_load = 1'b0; s_en = 1'b1;
        @(negedge clk);
        chk("R9 b0 lane0", 16'(s_lanes[4:0]), 16'h10);
        chk("R9 b0 lane1", 16'(s_lanes[9:5]), 16'h09);
        @(negedge clk);
        @(negedge clk);
        chk("R9 b1 lane0", 16'(s_lanes[4:0]), 16'h12);
        chk("R9 b1 lane1", 16'(s_lanes[9:5]), 16'h0D);
        s_en = 1'b0;
        @(negedge clk);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule